// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide flash bus. It watches write strobes that have already been brought into the clock domain and looks for the multi-cycle unlock sequences that guard every state-changing command. A recognised sequence can select one of five things. Read/reset and autoselect change what a read returns. Byte program, chip erase and sector erase produce a one-cycle start pulse to an embedded-algorithm engine. That pulse carries the opcode, the target address and data, or a mask of the sectors to erase.

Sector erase requests open an acceptance window. Further sector erase writes that arrive within the window add sectors to the mask, and each one restarts the window. Any other write aborts the request. When the window expires the engine is started. After that the decoder ignores all writes until the engine drops its busy flag. The read path is combinational from the bus address and returns one of three things: array data supplied from outside, the identifier bytes, or a status byte for polling.

Top module: `fcmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode: `rdData` equals `arrRdData`, and `engStart` is low.
- R2: Every command begins with a write of AAh to address 5555h and then a write of 55h to 2AAAh. Only address bits 14..0 are compared, so bits 16 and 15 are ignored. A wrong address or data value at any step silently returns the decoder to idle, and a later correct sequence is still accepted.
- R3: A third write of F0h to 5555h leaves the decoder in read mode and ends autoselect mode.
- R4: A third write of 90h to 5555h enters autoselect mode. A read with address bits 1..0 = 0 returns 01h, = 1 returns 20h, = 2 returns 01h if the sector given by address bits 16..14 is protected (00h if it is not), and = 3 returns 00h. The mode survives stray writes and lasts until R3.
- R5: A third write of A0h to 5555h, followed by a write to any address, raises `engStart` for exactly one cycle in the cycle after that write. `engOp` is then 1 (program), and `engAddr`/`engData` carry the full 17-bit address and the data of that write.
- R6: A program aimed at a protected sector never starts the engine (`protMask` bit n protects sector n, where the sector is address bits 16..14). A sector erase aimed at a protected sector adds nothing to the mask, and an erase whose mask ends up empty is dropped.
- R7: The erase path is 80h to 5555h, then AAh to 5555h, then 55h to 2AAAh. A following write of 10h to 5555h starts a chip erase (`engOp` = 2) with `engSectMask` = the inverse of `protMask`. If every sector is protected, nothing starts.
- R8: On the same erase path, a sixth write of 30h to any address opens the acceptance window for the sector given by address bits 16..14. At expiry, `engOp` is 3 (sector erase), and `engSectMask` has one bit set for each sector accepted.
- R9: Each further 30h write during the window adds its sector and restarts the window. `engStart` rises exactly `WIN_CYCLES` cycles after the last accepted 30h write.
- R10: Any other write during the window discards the collected sectors and returns the decoder to read mode, with no start.
- R11: From the start pulse until `engBusy` falls, all writes are ignored. Read mode resumes in the cycle after `engBusy` is seen low.
- R12: During the window and while the engine runs, reads return a status byte. Bit 7 is the inverse of bit 7 of the programmed data for a program and 0 for an erase. Bit 6 flips after every cycle with `busRdEn` high. Bit 3 is 1 once an erase has been started and 0 otherwise. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | One-cycle strobe per bus write |
| busRdEn | input | 1 | One-cycle strobe per bus read (advances the toggle bit) |
| busAddr | input | 17 | Bus address |
| busWrData | input | 8 | Bus write data |
| arrRdData | input | 8 | Array data for `busAddr` |
| protMask | input | 8 | Per-sector protection flags |
| rdData | output | 8 | Read data: array, identifier or status |
| engBusy | input | 1 | Engine busy, high from the cycle after the start until done |
| engStart | output | 1 | One-cycle start pulse to the engine |
| engOp | output | 2 | 1 program, 2 chip erase, 3 sector erase |
| engAddr | output | 17 | Program address |
| engData | output | 8 | Program data |
| engSectMask | output | 8 | Sectors to erase |

## Verification
A wrong sequencer state shows at the ports as a missing, extra or mistimed `engStart`. It can also show as a read byte from the wrong source: array, identifier or status. A sequencer that has drifted out of step is therefore exposed either on the first read issued after the offending write or on the start pulse that should follow. Window timing is checked to the exact cycle on both sides of expiry. Protection and abort cases are checked by confirming that no start appears over a span longer than the window.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  localparam int CMD_AW = 15;
  localparam logic [CMD_AW-1:0] ADR_FIRST  = 15'h5555;
  localparam logic [CMD_AW-1:0] ADR_SECOND = 15'h2AAA;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] CODE_RESET = 8'hF0;
  localparam logic [7:0] CODE_IDENT = 8'h90;
  localparam logic [7:0] CODE_PROG  = 8'hA0;
  localparam logic [7:0] CODE_ERSU  = 8'h80;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SECT  = 8'h30;

  localparam logic [7:0] IDENT_MAKER = 8'h01;
  localparam logic [7:0] IDENT_PART  = 8'h20;

  typedef enum logic [3:0] {
    ST_READ, ST_C1, ST_C2, ST_PROG, ST_E0, ST_E1, ST_E2,
    ST_WIN, ST_LAUNCH, ST_BUSY
  } seqState_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0, OP_PROG = 2'd1, OP_CHIP = 2'd2, OP_SECT = 2'd3
  } engOp_t;

  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0, RD_IDENT = 2'd1, RD_STATUS = 2'd2
  } rdMode_t;

  typedef struct packed {
    logic    capProg;
    logic    sectAdd;
    logic    maskClear;
    logic    chipLoad;
    logic    winRun;
    rdMode_t rdMode;
    logic    eraseRun;
    logic    progPoll;
  } dpCtl_t;

endpackage

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [CMD_AW-1:0] cmdAddr,
  input  logic [7:0]        busWrData,
  input  logic              sectProt,
  input  logic              allProt,
  input  logic              maskEmpty,
  input  logic              winExpired,
  input  logic              engBusy,
  output dpCtl_t            dpCtl,
  output logic              engStart,
  output engOp_t            engOp
);

  seqState_t state, stateNxt;
  engOp_t    opReg, opNxt;
  logic      identMode, identNxt;

  logic isKeyA, isKeyB, atCmdAddr, statusPhase;

  assign atCmdAddr = (cmdAddr == ADR_FIRST);
  assign isKeyA    = atCmdAddr && (busWrData == KEY_FIRST);
  assign isKeyB    = (cmdAddr == ADR_SECOND) && (busWrData == KEY_SECOND);
  assign statusPhase = (state == ST_WIN) || (state == ST_LAUNCH) || (state == ST_BUSY);

  always_comb begin
    stateNxt = state;
    opNxt    = opReg;
    identNxt = identMode;
    dpCtl    = '0;
    dpCtl.winRun = (state == ST_WIN);
    unique case (state)
      ST_READ: if (busWrEn && isKeyA) stateNxt = ST_C1;
      ST_C1:   if (busWrEn) stateNxt = isKeyB ? ST_C2 : ST_READ;
      ST_C2: if (busWrEn) begin
        stateNxt = ST_READ;
        if (atCmdAddr) begin
          unique case (busWrData)
            CODE_RESET: identNxt = 1'b0;
            CODE_IDENT: identNxt = 1'b1;
            CODE_PROG:  stateNxt = ST_PROG;
            CODE_ERSU: begin
              stateNxt        = ST_E0;
              dpCtl.maskClear = 1'b1;
            end
            default: stateNxt = ST_READ;
          endcase
        end
      end
      ST_PROG: if (busWrEn) begin
        if (sectProt) stateNxt = ST_READ;
        else begin
          dpCtl.capProg = 1'b1;
          opNxt         = OP_PROG;
          stateNxt      = ST_LAUNCH;
        end
      end
      ST_E0: if (busWrEn) stateNxt = isKeyA ? ST_E1 : ST_READ;
      ST_E1: if (busWrEn) stateNxt = isKeyB ? ST_E2 : ST_READ;
      ST_E2: if (busWrEn) begin
        stateNxt = ST_READ;
        if (atCmdAddr && busWrData == CODE_CHIP) begin
          dpCtl.chipLoad = 1'b1;
          if (!allProt) begin
            opNxt    = OP_CHIP;
            stateNxt = ST_LAUNCH;
          end
        end else if (busWrData == CODE_SECT) begin
          dpCtl.sectAdd = 1'b1;
          opNxt         = OP_SECT;
          stateNxt      = ST_WIN;
        end
      end
      ST_WIN: begin
        if (busWrEn) begin
          if (busWrData == CODE_SECT) dpCtl.sectAdd = 1'b1;
          else begin
            dpCtl.maskClear = 1'b1;
            stateNxt        = ST_READ;
          end
        end else if (winExpired) begin
          stateNxt = maskEmpty ? ST_READ : ST_LAUNCH;
        end
      end
      ST_LAUNCH: stateNxt = ST_BUSY;
      ST_BUSY:   if (!engBusy) stateNxt = ST_READ;
      default:   stateNxt = ST_READ;
    endcase

    if (statusPhase)    dpCtl.rdMode = RD_STATUS;
    else if (identMode) dpCtl.rdMode = RD_IDENT;
    else                dpCtl.rdMode = RD_ARRAY;
    dpCtl.eraseRun = ((state == ST_LAUNCH) || (state == ST_BUSY)) && (opReg != OP_PROG);
    dpCtl.progPoll = (opReg == OP_PROG);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_READ;
      opReg     <= OP_NONE;
      identMode <= 1'b0;
    end else begin
      state     <= stateNxt;
      opReg     <= opNxt;
      identMode <= identNxt;
    end
  end

  assign engStart = (state == ST_LAUNCH);
  assign engOp    = opReg;

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R10
  win_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WIN) && busWrEn && (busWrData != CODE_SECT) |=> (state == ST_READ) && !engStart);

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) && busWrEn |=> (state == ST_BUSY) || (state == ST_READ));

endmodule

// File: rtl/fcmd_dpath.sv
module fcmd_dpath
  import fcmd_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int SECT_W     = 3,
  parameter int WIN_CYCLES = 4000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtl_t                ctl,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [7:0]            busWrData,
  input  logic                  busRdEn,
  input  logic [7:0]            arrRdData,
  input  logic [(1<<SECT_W)-1:0] protMask,
  output logic                  sectProt,
  output logic                  allProt,
  output logic                  maskEmpty,
  output logic                  winExpired,
  output logic [7:0]            rdData,
  output logic [ADDR_W-1:0]     engAddr,
  output logic [7:0]            engData,
  output logic [(1<<SECT_W)-1:0] engSectMask
);

  localparam int NUM_SECT = 1 << SECT_W;
  localparam int CNT_W    = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CYCLES - 1);

  logic [SECT_W-1:0]   sectIdx;
  logic [NUM_SECT-1:0] sectMask, maskNxt;
  logic [CNT_W-1:0]    winCnt;
  logic [ADDR_W-1:0]   progAddr;
  logic [7:0]          progData;
  logic                togBit;

  assign sectIdx   = busAddr[ADDR_W-1 -: SECT_W];
  assign sectProt  = protMask[sectIdx];
  assign allProt   = &protMask;
  assign maskEmpty = (sectMask == '0);

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    assign maskNxt[s] = ctl.maskClear ? 1'b0 :
                        ctl.chipLoad  ? ~protMask[s] :
                        (ctl.sectAdd && sectIdx == SECT_W'(s) && !protMask[s]) ? 1'b1 :
                        sectMask[s];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sectMask <= '0;
      winCnt   <= '0;
      progAddr <= '0;
      progData <= '0;
      togBit   <= 1'b0;
    end else begin
      sectMask <= maskNxt;
      if (ctl.sectAdd)                        winCnt <= '0;
      else if (ctl.winRun && winCnt != CNT_LAST) winCnt <= winCnt + 1'b1;
      if (ctl.capProg) begin
        progAddr <= busAddr;
        progData <= busWrData;
      end
      if (busRdEn && ctl.rdMode == RD_STATUS) togBit <= ~togBit;
    end
  end

  assign winExpired = ctl.winRun && !ctl.sectAdd && (winCnt == CNT_LAST);

  always_comb begin
    unique case (ctl.rdMode)
      RD_STATUS: rdData = {ctl.progPoll & ~progData[7], togBit, 2'b00, ctl.eraseRun, 3'b000};
      RD_IDENT: begin
        unique case (busAddr[1:0])
          2'd0:    rdData = IDENT_MAKER;
          2'd1:    rdData = IDENT_PART;
          2'd2:    rdData = {7'b0, sectProt};
          default: rdData = 8'h00;
        endcase
      end
      default:   rdData = arrRdData;
    endcase
  end

  assign engAddr     = progAddr;
  assign engData     = progData;
  assign engSectMask = sectMask;

  // R9
  win_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= CNT_LAST);

  // R6
  prot_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sectAdd && !ctl.maskClear && !ctl.chipLoad && sectProt |=> $stable(sectMask));

endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int SECT_W     = 3,
  parameter int WIN_CYCLES = 4000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWrEn,
  input  logic                   busRdEn,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [7:0]             busWrData,
  input  logic [7:0]             arrRdData,
  input  logic [(1<<SECT_W)-1:0] protMask,
  output logic [7:0]             rdData,
  input  logic                   engBusy,
  output logic                   engStart,
  output logic [1:0]             engOp,
  output logic [ADDR_W-1:0]      engAddr,
  output logic [7:0]             engData,
  output logic [(1<<SECT_W)-1:0] engSectMask
);

  dpCtl_t dpCtl;
  engOp_t opInt;
  logic   sectProt, allProt, maskEmpty, winExpired;

  fcmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .cmdAddr    (busAddr[CMD_AW-1:0]),
    .busWrData  (busWrData),
    .sectProt   (sectProt),
    .allProt    (allProt),
    .maskEmpty  (maskEmpty),
    .winExpired (winExpired),
    .engBusy    (engBusy),
    .dpCtl      (dpCtl),
    .engStart   (engStart),
    .engOp      (opInt)
  );

  fcmd_dpath #(
    .ADDR_W     (ADDR_W),
    .SECT_W     (SECT_W),
    .WIN_CYCLES (WIN_CYCLES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (dpCtl),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busRdEn     (busRdEn),
    .arrRdData   (arrRdData),
    .protMask    (protMask),
    .sectProt    (sectProt),
    .allProt     (allProt),
    .maskEmpty   (maskEmpty),
    .winExpired  (winExpired),
    .rdData      (rdData),
    .engAddr     (engAddr),
    .engData     (engData),
    .engSectMask (engSectMask)
  );

  assign engOp = opInt;

  // R6
  prog_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    engStart && (engOp == 2'd1) |-> !protMask[engAddr[ADDR_W-1 -: SECT_W]]);

  // R8
  sect_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    engStart && (engOp == 2'd3) |-> (engSectMask != '0));

  // R11
  busy_nostart_chk: assert property (@(posedge clk) disable iff (!rstN)
    engBusy |=> !engStart);

endmodule

// File: tb/fcmd_decoder_bench.sv
module fcmd_decoder_bench;

  localparam int W        = 64;
  localparam int BUSY_LEN = 40;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn, busRdEn;
  logic [16:0] busAddr;
  logic [7:0]  busWrData, arrRdData, protMask, rdData;
  logic        engBusy, engStart;
  logic [1:0]  engOp;
  logic [16:0] engAddr;
  logic [7:0]  engData, engSectMask;

  int tests = 0, fails = 0, startCount = 0, busyCnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign arrRdData = busAddr[7:0] ^ 8'hC3;

  fcmd_decoder #(.WIN_CYCLES(W)) u_fcmd_decoder (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .arrRdData(arrRdData),
    .protMask(protMask), .rdData(rdData), .engBusy(engBusy),
    .engStart(engStart), .engOp(engOp), .engAddr(engAddr),
    .engData(engData), .engSectMask(engSectMask)
  );

  // engine model, acting away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      engBusy <= 1'b0;
      busyCnt <= 0;
    end else if (engStart) begin
      engBusy    <= 1'b1;
      busyCnt    <= BUSY_LEN;
      startCount <= startCount + 1;
    end else if (busyCnt != 0) begin
      busyCnt <= busyCnt - 1;
      if (busyCnt == 1) engBusy <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] v);
    busAddr = a;
    #1 v = rdData;
  endtask

  task automatic statusRd(input logic [16:0] a, output logic [7:0] v);
    busAddr = a; busRdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic cmd3(input logic [7:0] code);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, code);
  endtask

  task automatic erase6(input logic [16:0] a, input logic [7:0] code);
    cmd3(8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(a, code);
  endtask

  task automatic waitIdle;
    do begin @(negedge clk); #1; end while (engBusy);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(17'h00123, v);
    chk("R1 array read", v, 8'h23 ^ 8'hC3);
    chk("R1 no start", engStart, 1'b0);
  endtask

  task automatic t_unlock;
    logic [7:0] v;
    wr(17'h1D555, 8'hAA); wr(17'h1AAAA, 8'h55); wr(17'h0D555, 8'h90);
    rd(17'h00000, v);
    chk("R2 upper bits ignored", v, 8'h01);
    cmd3(8'hF0);
    rd(17'h00000, v);
    chk("R3 reset leaves ident", v, 8'hC3);
    wr(17'h05555, 8'hAA); wr(17'h02AAB, 8'h55); wr(17'h05555, 8'h90);
    rd(17'h00000, v);
    chk("R2 bad address rejected", v, 8'hC3);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h54); wr(17'h05555, 8'h90);
    rd(17'h00001, v);
    chk("R2 bad data rejected", v, 8'h01 ^ 8'hC3);
    cmd3(8'h90);
    rd(17'h00001, v);
    chk("R2 recovery after error", v, 8'h20);
    cmd3(8'hF0);
  endtask

  task automatic t_ident;
    logic [7:0] v;
    protMask = 8'h24;
    cmd3(8'h90);
    rd(17'h00000, v); chk("R4 offset0", v, 8'h01);
    rd(17'h00001, v); chk("R4 offset1", v, 8'h20);
    rd(17'h08002, v); chk("R4 protected sector", v, 8'h01);
    rd(17'h04002, v); chk("R4 open sector", v, 8'h00);
    rd(17'h14003, v); chk("R4 offset3", v, 8'h00);
    wr(17'h00000, 8'h77);
    rd(17'h00001, v); chk("R4 persists", v, 8'h20);
    cmd3(8'hF0);
    rd(17'h00001, v); chk("R3 exit ident", v, 8'h01 ^ 8'hC3);
    protMask = 8'h00;
  endtask

  task automatic t_program;
    logic [7:0] v1, v2, v;
    int sc;
    cmd3(8'hA0);
    wr(17'h13456, 8'h5A);
    chk("R5 start", engStart, 1'b1);
    chk("R5 op", engOp, 2'd1);
    chk("R5 addr", engAddr, 17'h13456);
    chk("R5 data", engData, 8'h5A);
    statusRd(17'h13456, v1);
    chk("R12 program status", v1 & 8'hBF, 8'h80);
    chk("R5 single pulse", engStart, 1'b0);
    statusRd(17'h13456, v2);
    chk("R12 toggle", v1[6] ^ v2[6], 1'b1);
    #2 sc = startCount;
    cmd3(8'hA0);
    wr(17'h00010, 8'h11);
    @(negedge clk);
    #2 chk("R11 writes ignored while busy", startCount, sc);
    waitIdle();
    rd(17'h00010, v);
    chk("R11 read mode after busy", v, 8'h10 ^ 8'hC3);
  endtask

  task automatic t_protect;
    logic [7:0] v;
    int sc;
    protMask = 8'h24;
    #2 sc = startCount;
    cmd3(8'hA0);
    wr(17'h14020, 8'h33);
    repeat (3) @(negedge clk);
    #2 chk("R6 program to protected", startCount, sc);
    erase6(17'h08000, 8'h30);
    repeat (W + 4) @(negedge clk);
    #2 chk("R6 erase of protected", startCount, sc);
    rd(17'h00044, v);
    chk("R6 back in read", v, 8'h44 ^ 8'hC3);
    erase6(17'h05555, 8'h10);
    chk("R7 chip start", engStart, 1'b1);
    chk("R7 chip op", engOp, 2'd2);
    chk("R7 chip mask", engSectMask, 8'hDB);
    waitIdle();
    protMask = 8'hFF;
    #2 sc = startCount;
    erase6(17'h05555, 8'h10);
    repeat (4) @(negedge clk);
    #2 chk("R7 all protected", startCount, sc);
    protMask = 8'h00;
  endtask

  task automatic t_sector;
    logic [7:0] v;
    erase6(17'h05000, 8'h30);
    rd(17'h05000, v);
    chk("R12 window status", v & 8'h88, 8'h00);
    repeat (W - 1) @(negedge clk);
    chk("R9 not before window end", engStart, 1'b0);
    @(negedge clk);
    chk("R8 start at expiry", engStart, 1'b1);
    chk("R8 op", engOp, 2'd3);
    chk("R8 mask", engSectMask, 8'h02);
    rd(17'h05000, v);
    chk("R12 erase running status", v & 8'h88, 8'h08);
    waitIdle();
  endtask

  task automatic t_multi;
    erase6(17'h1C000, 8'h30);
    repeat (20) @(negedge clk);
    wr(17'h0C123, 8'h30);
    repeat (20) @(negedge clk);
    wr(17'h1C555, 8'h30);
    repeat (W - 1) @(negedge clk);
    chk("R9 restart delays start", engStart, 1'b0);
    @(negedge clk);
    chk("R9 start after last", engStart, 1'b1);
    chk("R9 collected mask", engSectMask, 8'h88);
    waitIdle();
  endtask

  task automatic t_abort;
    logic [7:0] v;
    int sc;
    #2 sc = startCount;
    erase6(17'h10000, 8'h30);
    repeat (10) @(negedge clk);
    wr(17'h00000, 8'hF0);
    repeat (W + 5) @(negedge clk);
    #2 chk("R10 abort no start", startCount, sc);
    rd(17'h00005, v);
    chk("R10 read mode", v, 8'h05 ^ 8'hC3);
  endtask

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0;
    busAddr = '0; busWrData = '0; protMask = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_ident();
    t_program();
    t_protect();
    t_sector();
    t_multi();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule